// File: doc/BRIEF.md
# Parallel-Lane Key Match Engine

This block takes 32-bit unsigned keys from a show-ahead FIFO. For each key it searches a table of stored 32-bit entries for an equal value. A host processor loads the table through a simple write port, and the entry address it supplies is the entry index. After each search the block gives a one-cycle done pulse. The pulse comes with a match flag and, on a hit, the index of the matching entry.

The table is too large to compare every entry in one cycle. It is therefore split across `LANES` memory banks. Entry `i` lives in bank `i mod LANES` at row `i / LANES`. The engine reads one row from every bank per cycle and compares all lanes with the key in parallel. The memory read, the comparison and the priority pick are each a registered stage, and the scan stops at the first row that holds a hit. Each entry carries a valid bit, so an entry that was never written cannot match. A clear command drops every valid bit at once. While a search is running, table writes and clears are held off with a wait signal, so every search sees one consistent table.

Top module: `keyMatchEngine`

## Requirements
- R1: While `rstN` is low and after its release, `srchDone`, `matchFlag`, `matchIdx` and `tblWait` are all 0. A reset during a search abandons that search without a done pulse.
- R2: `fifoRdEn` is high only when the engine is idle (`tblWait` low) and `fifoEmpty` is low. One key is taken per search.
- R3: When the key equals a valid entry, the done pulse comes with `matchFlag`=1 and `matchIdx` equal to that entry's index.
- R4: When no valid entry equals the key, the done pulse comes with `matchFlag`=0 and `matchIdx`=0.
- R5: An entry that has not been written since reset or since the last clear never matches, whatever the key.
- R6: A one-cycle `tblClear` accepted while idle invalidates every entry.
- R7: When several entries equal the key, the lowest index is reported.
- R8: `srchDone` is a one-cycle pulse. It rises on the clock edge r+3 after the edge that pops the key, where r = index / LANES is the row of the reported hit. On a miss, r = ceil(NUM_ENTRIES / LANES) - 1.
- R9: `tblWait` is high from the pop edge until the done pulse. A write or clear requested meanwhile has no effect until `tblWait` falls, and is then accepted on the next edge where the request is still held.
- R10: `matchFlag` and `matchIdx` change only together with a done pulse and hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEmpty | input | 1 | Key FIFO has no data |
| fifoData | input | 32 | Head-of-FIFO key (show-ahead) |
| fifoRdEn | output | 1 | Pops the head key at this edge |
| tblWrEn | input | 1 | Table write request |
| tblWrAddr | input | IDX_W | Entry index to write |
| tblWrData | input | 32 | Entry value |
| tblClear | input | 1 | Invalidate-all request |
| tblWait | output | 1 | Search busy; write and clear requests are held |
| srchDone | output | 1 | One-cycle search-finished pulse |
| matchFlag | output | 1 | Result of the last search: hit |
| matchIdx | output | 32 | Index of the lowest matching entry, 0 on a miss |

## Verification
The bench stores the same value at entries 9 and 50 and expects index 9. A design that picks the highest lane, or that keeps scanning after the first hit, would report 50. It searches for the value of an unwritten entry, and for any value after a clear. A design that ignores the valid bits would then match stale or undefined memory. It measures the done latency for hits in row 0, in a middle row and in the last lane of the last row, so an off-by-one in the row counter or in the pipeline flush shows up as a wrong cycle count or a lost last row. It also asks for a table write in the middle of a search. A design that fails to hold the write off would report a hit for a value that was not yet in the table.

// File: rtl/keyMatchPkg.sv
package keyMatchPkg;
  localparam int KEY_W = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic loadKey;
    logic issue;
    logic writeTable;
    logic clearTable;
  } kmCtl_t;
endpackage

// File: rtl/kmControl.sv
module kmControl
  import keyMatchPkg::*;
#(
  parameter int ROWS  = 16,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEmpty,
  input  logic             wrReq,
  input  logic             clrReq,
  input  logic             finish,
  output kmCtl_t           ctl,
  output logic [ROW_W-1:0] row,
  output logic             busy
);
  typedef enum logic {S_IDLE, S_SCAN} state_t;
  state_t state;
  logic   allIssued;

  always_comb begin
    busy           = (state == S_SCAN);
    ctl.loadKey    = !busy && !fifoEmpty;
    ctl.issue      = busy && !finish && !allIssued;
    ctl.writeTable = wrReq && !busy;
    ctl.clearTable = clrReq && !busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      row       <= '0;
      allIssued <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (ctl.loadKey) begin
          state     <= S_SCAN;
          row       <= '0;
          allIssued <= 1'b0;
        end
        default: begin
          if (finish) state <= S_IDLE;
          else if (ctl.issue) begin
            if (row == ROW_W'(ROWS - 1)) allIssued <= 1'b1;
            else row <= row + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/kmDatapath.sv
module kmDatapath
  import keyMatchPkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int LANES       = 4,
  parameter int ROWS        = 16,
  parameter int ROW_W       = 4,
  parameter int LANE_W      = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  kmCtl_t                  ctl,
  input  logic [ROW_W-1:0]        row,
  input  logic [KEY_W-1:0]        fifoData,
  input  logic [ROW_W+LANE_W-1:0] wrAddr,
  input  logic [KEY_W-1:0]        wrData,
  output logic                    finish,
  output logic                    srchDone,
  output logic                    matchFlag,
  output logic [31:0]             matchIdx
);
  logic [KEY_W-1:0]  keyReg;
  logic [LANES-1:0]  eqNow, hitVec;
  logic [ROW_W-1:0]  rdRow, cmpRow;
  logic              rdValid, cmpValid, anyHit;
  logic [LANE_W-1:0] firstLane;
  logic              addrOk;

  assign addrOk = 32'(wrAddr) < NUM_ENTRIES;

  always_ff @(posedge clk)
    if (ctl.loadKey) keyReg <= fifoData;

  // one bank per lane: memory, valid bits, registered read
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [KEY_W-1:0] mem [ROWS];
    logic [ROWS-1:0]  vbits;
    logic [KEY_W-1:0] rdWord;
    logic             rdVal;
    logic             laneWe;

    assign laneWe = ctl.writeTable && addrOk &&
                    (wrAddr[LANE_W-1:0] == LANE_W'(l));

    always_ff @(posedge clk) begin
      if (laneWe) mem[wrAddr[ROW_W+LANE_W-1:LANE_W]] <= wrData;
      if (ctl.issue) begin
        rdWord <= mem[row];
        rdVal  <= vbits[row];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN || ctl.clearTable) vbits <= '0;
      else if (laneWe) vbits[wrAddr[ROW_W+LANE_W-1:LANE_W]] <= 1'b1;
    end

    assign eqNow[l] = rdVal && (rdWord == keyReg);
  end

  // read stage and compare stage bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      cmpValid <= 1'b0;
      hitVec   <= '0;
      rdRow    <= '0;
      cmpRow   <= '0;
    end else begin
      rdValid  <= ctl.issue;
      rdRow    <= row;
      cmpValid <= rdValid && !finish;
      cmpRow   <= rdRow;
      hitVec   <= eqNow & {LANES{rdValid}};
    end
  end

  // lowest lane wins
  always_comb begin
    firstLane = '0;
    for (int l = LANES - 1; l >= 0; l--)
      if (hitVec[l]) firstLane = LANE_W'(l);
  end

  assign anyHit = |hitVec;
  assign finish = cmpValid && (anyHit || cmpRow == ROW_W'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srchDone  <= 1'b0;
      matchFlag <= 1'b0;
      matchIdx  <= '0;
    end else begin
      srchDone <= finish;
      if (finish) begin
        matchFlag <= anyHit;
        matchIdx  <= anyHit ? 32'({cmpRow, firstLane}) : 32'd0;
      end
    end
  end
endmodule

// File: rtl/keyMatchEngine.sv
module keyMatchEngine
  import keyMatchPkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int LANES       = 4,   // power of two, at least 2
  localparam int LANE_W     = $clog2(LANES),
  localparam int ROWS       = (NUM_ENTRIES + LANES - 1) / LANES,
  localparam int ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int IDX_W      = ROW_W + LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEmpty,
  input  logic [31:0]      fifoData,
  output logic             fifoRdEn,
  input  logic             tblWrEn,
  input  logic [IDX_W-1:0] tblWrAddr,
  input  logic [31:0]      tblWrData,
  input  logic             tblClear,
  output logic             tblWait,
  output logic             srchDone,
  output logic             matchFlag,
  output logic [31:0]      matchIdx
);
  kmCtl_t           ctl;
  logic [ROW_W-1:0] row;
  logic             finish;

  kmControl #(.ROWS(ROWS), .ROW_W(ROW_W)) u_ctl (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .wrReq(tblWrEn),
    .clrReq(tblClear), .finish(finish), .ctl(ctl), .row(row), .busy(tblWait)
  );

  kmDatapath #(.NUM_ENTRIES(NUM_ENTRIES), .LANES(LANES), .ROWS(ROWS),
               .ROW_W(ROW_W), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .row(row), .fifoData(fifoData),
    .wrAddr(tblWrAddr), .wrData(tblWrData), .finish(finish),
    .srchDone(srchDone), .matchFlag(matchFlag), .matchIdx(matchIdx)
  );

  assign fifoRdEn = ctl.loadKey;
endmodule

// File: rtl/kmChecker.sv
module kmChecker (
  input logic        clk,
  input logic        rstN,
  input logic        fifoEmpty,
  input logic        fifoRdEn,
  input logic        tblWait,
  input logic        srchDone,
  input logic        matchFlag,
  input logic [31:0] matchIdx
);
  // R2
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoRdEn |-> !fifoEmpty);
  // R2
  pop_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    tblWait |-> !fifoRdEn);
  // R9
  busy_after_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoRdEn |=> tblWait);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    srchDone |=> !srchDone);
  // R4
  miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !matchFlag |-> (matchIdx == 32'd0));
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !srchDone |=> ($stable(matchFlag) && $stable(matchIdx)) || srchDone);
endmodule

bind keyMatchEngine kmChecker u_kmChecker (
  .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .fifoRdEn(fifoRdEn),
  .tblWait(tblWait), .srchDone(srchDone), .matchFlag(matchFlag),
  .matchIdx(matchIdx)
);

// File: tb/keyMatchEngine_bench.sv
`timescale 1ns/1ps
module keyMatchEngine_bench;
  localparam int N = 64, L = 4, ROWS = N / L, IDX_W = 6;
  localparam int MISS_LAT = ROWS + 2;
  localparam logic [31:0] BASE = 32'hA500_0000;

  typedef struct packed {
    logic [31:0] key;
    logic        hit;
    logic [31:0] idx;
    logic [31:0] lat;
  } vec_t;

  // entry i holds BASE + 13*i, except: 20 unwritten, 50 holds entry 9's value, 63 = all ones
  localparam vec_t VECS [9] = '{
    '{BASE,              1'b1, 32'd0,  32'd3},
    '{BASE + 32'd39,     1'b1, 32'd3,  32'd3},
    '{BASE + 32'd65,     1'b1, 32'd5,  32'd4},
    '{BASE + 32'd117,    1'b1, 32'd9,  32'd5},
    '{32'hFFFF_FFFF,     1'b1, 32'd63, 32'd18},
    '{BASE + 32'd806,    1'b1, 32'd62, 32'd18},
    '{BASE + 32'd260,    1'b0, 32'd0,  32'd18},
    '{32'h1234_5678,     1'b0, 32'd0,  32'd18},
    '{BASE + 32'd650,    1'b0, 32'd0,  32'd18}
  };

  logic clk = 0, rstN = 0;
  logic fifoEmpty = 1, tblWrEn = 0, tblClear = 0;
  logic [31:0] fifoData = '0, tblWrData = '0;
  logic [IDX_W-1:0] tblWrAddr = '0;
  logic fifoRdEn, tblWait, srchDone, matchFlag;
  logic [31:0] matchIdx;
  int testCnt = 0, failCnt = 0, cycles = 0;

  always #10 clk = ~clk;

  keyMatchEngine #(.NUM_ENTRIES(N), .LANES(L)) u_keyMatchEngine (
    .clk(clk), .rstN(rstN), .fifoEmpty(fifoEmpty), .fifoData(fifoData),
    .fifoRdEn(fifoRdEn), .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr),
    .tblWrData(tblWrData), .tblClear(tblClear), .tblWait(tblWait),
    .srchDone(srchDone), .matchFlag(matchFlag), .matchIdx(matchIdx)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failCnt = failCnt + 1;
      $display("FAIL watchdog got %0d cycles exp < 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic writeEntry(input int idx, input logic [31:0] val);
    @(negedge clk);
    tblWrEn = 1; tblWrAddr = IDX_W'(idx); tblWrData = val;
    while (tblWait) @(negedge clk);
    @(negedge clk);
    tblWrEn = 0;
  endtask

  task automatic startSearch(input logic [31:0] k);
    @(negedge clk);
    fifoData = k; fifoEmpty = 0;
    while (!fifoRdEn) @(negedge clk);
    @(posedge clk);
    #1 fifoEmpty = 1;
  endtask

  task automatic waitDone(output int lat);
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!srchDone && lat < 200);
  endtask

  task automatic search(input logic [31:0] k, output logic h, output logic [31:0] ix, output int lat);
    startSearch(k);
    waitDone(lat);
    h = matchFlag; ix = matchIdx;
  endtask

  initial begin
    logic h; logic [31:0] ix; int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!srchDone && !matchFlag && matchIdx == 0 && !tblWait, "R1 in reset", {srchDone, matchFlag, tblWait}, 0);
    rstN = 1;
    @(negedge clk);
    check(!srchDone && !matchFlag && matchIdx == 0 && !tblWait, "R1 after release", matchIdx, 0);
    // R2 no pop while empty
    check(!fifoRdEn, "R2 empty no pop", fifoRdEn, 0);

    for (int i = 0; i < N; i++) begin
      if (i == 20) continue;
      writeEntry(i, (i == 50) ? BASE + 32'd117 : (i == 63) ? 32'hFFFF_FFFF : BASE + 32'(13 * i));
    end

    // vector table: R3 R4 R5 R7 R8
    for (int v = 0; v < 9; v++) begin
      search(VECS[v].key, h, ix, lat);
      check(h == VECS[v].hit, $sformatf("R3/R4 flag vec%0d", v), 32'(h), 32'(VECS[v].hit));
      check(ix == VECS[v].idx, $sformatf("R3/R7 idx vec%0d", v), ix, VECS[v].idx);
      check(32'(lat) == VECS[v].lat, $sformatf("R8 latency vec%0d", v), 32'(lat), VECS[v].lat);
      @(negedge clk);
      check(!srchDone, "R8 one-cycle pulse", 32'(srchDone), 0);
      check(matchFlag == VECS[v].hit && matchIdx == VECS[v].idx, "R10 hold", matchIdx, VECS[v].idx);
    end

    // R5 unwritten entry: dedicated lookup of its value
    search(BASE + 32'd260, h, ix, lat);
    check(!h, "R5 unwritten entry", 32'(h), 0);

    // R9 write held during a search, then accepted
    startSearch(32'h0BAD_F00D);
    @(negedge clk);
    tblWrEn = 1; tblWrAddr = 6'd20; tblWrData = 32'h0BAD_F00D;
    fifoEmpty = 0; fifoData = BASE;
    check(tblWait, "R9 wait during search", 32'(tblWait), 1);
    check(!fifoRdEn, "R2 no pop while busy", 32'(fifoRdEn), 0);
    fifoEmpty = 1;
    waitDone(lat);
    check(!matchFlag, "R9 held write not seen", 32'(matchFlag), 0);
    check(32'(lat) == MISS_LAT, "R8 miss latency", 32'(lat), MISS_LAT);
    @(negedge clk);
    tblWrEn = 0;
    search(32'h0BAD_F00D, h, ix, lat);
    check(h && ix == 20, "R9 write applied", ix, 20);
    check(lat == 8, "R8 row5 latency", 32'(lat), 8);

    // R6 clear invalidates everything
    @(negedge clk); tblClear = 1;
    @(negedge clk); tblClear = 0;
    search(BASE, h, ix, lat);
    check(!h && ix == 0, "R6 cleared entry 0", ix, 0);
    search(32'hFFFF_FFFF, h, ix, lat);
    check(!h, "R6 cleared entry 63", 32'(h), 0);

    // R1 reset during a search after a hit
    writeEntry(7, 32'h0000_0777);
    search(32'h0000_0777, h, ix, lat);
    check(h && ix == 7, "R3 rewritten entry", ix, 7);
    startSearch(32'h0000_0777);
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    check(!srchDone && !matchFlag && matchIdx == 0 && !tblWait, "R1 mid-search reset", matchIdx, 0);
    rstN = 1;
    repeat (25) begin
      @(negedge clk);
      if (srchDone) check(1'b0, "R1 abandoned search done", 1, 0);
    end

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule